// File: doc/BRIEF.md
# Queued Command Tag Tracker

This block keeps the per-port bookkeeping for native queued read and write commands. When a host-to-device register frame is presented, it pulls out the queue tag, the 48-bit starting block address and the 16-bit block count. If the tag is free and the opcode is a queued read or a queued write, it marks the tag as outstanding and emits a one-cycle start pulse carrying the decoded fields toward the data mover. A tag that is already outstanding makes the block drop the frame. Any other opcode leaves the tag free and starts nothing.

Completion events arrive as a tag plus an error flag. Each one frees the tag and clears its bit in the active-tag bitmap. A failure also records the tag in the error bitmap and updates the error and status bytes. When frame reception is enabled and the receive area is valid, the tag joins a running finished mask and the block emits a set-device-bits frame together with an interrupt pulse. A destructive read of the active bitmap first removes the finished tags from it and then empties the finished mask.

Top module: `ncq_tag_tracker`

## Requirements
- R1: After reset no tag is outstanding, the active and error bitmaps are zero, and neither start_valid nor sdb_irq is asserted.
- R2: Frame fields are little-endian bytes of iss_frame (byte k at bits 8k+7..8k). The opcode is byte 2. The tag is byte 12 shifted right by 3. The block address is {byte 10, byte 9, byte 8, byte 6, byte 5, byte 4}, most significant first. The count is {byte 11, byte 3}. Opcode 0x60 is a queued read (start_is_read=1) and 0x61 is a queued write (start_is_read=0).
- R3: A frame accepted on a clock edge raises start_valid for exactly the following cycle with the decoded fields, and the tag's bit in tags_used is set from that cycle on.
- R4: A frame whose tag is already outstanding is dropped: no start pulse, and tags_used is unchanged.
- R5: A frame with any opcode other than 0x60 or 0x61 starts nothing and leaves its tag not outstanding.
- R6: A completion frees its tag in tags_used and clears its bit in the active bitmap in the next cycle.
- R7: A failed completion sets the tag's bit in serr. It sets the error byte to 0x04 and the status byte to 0x41.
- R8: A successful completion sets the status byte to 0x50 and leaves the error byte at its previous value.
- R9: With reception enabled, a completion pulses sdb_irq in the next cycle. sdb_frame then holds the error byte in byte 0, zero in byte 1, status AND 0x77 in byte 2, zero in byte 3, and the accumulated finished mask as a little-endian word in bytes 4..7.
- R10: When fis_rx_en or rx_area_ok is low, a completion emits no sdb_irq and does not add its tag to the finished mask.
- R11: act_rd_data shows the active bitmap with the finished tags removed. An act_rd strobe commits that value to the active bitmap and empties the finished mask.
- R12: port_rst frees every tag in tags_used.
- R13: A completion and a new frame for the same tag in one cycle are handled completion first, so the frame is accepted.
- R14: act_set_en ORs act_set_mask into the active bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_rst | input | 1 | Frees all tags |
| iss_valid | input | 1 | Register frame present this cycle |
| iss_frame | input | 128 | Host-to-device register frame, 16 bytes |
| cpl_valid | input | 1 | Completion event |
| cpl_tag | input | TAG_W | Tag being completed |
| cpl_err | input | 1 | Completion failed |
| fis_rx_en | input | 1 | Frame reception enabled |
| rx_area_ok | input | 1 | Receive area valid |
| act_set_en | input | 1 | Set bits in the active bitmap |
| act_set_mask | input | NUM_TAGS | Bits to set |
| act_rd | input | 1 | Destructive read of the active bitmap |
| act_rd_data | output | NUM_TAGS | Active bitmap with finished tags removed |
| start_valid | output | 1 | One-cycle start pulse |
| start_tag | output | TAG_W | Started tag |
| start_lba | output | 48 | Started block address |
| start_cnt | output | 16 | Started block count |
| start_is_read | output | 1 | Started command is a read |
| tags_used | output | NUM_TAGS | Outstanding-tag flags |
| serr | output | NUM_TAGS | Error bitmap |
| sdb_irq | output | 1 | Set-device-bits frame written, interrupt raised |
| sdb_frame | output | 64 | Last set-device-bits frame |

## Verification
A corrupted outstanding flag shows up within one frame at the ports. A stuck-set flag swallows the next start pulse for that tag. A stuck-clear flag lets a duplicate through as a second start pulse. A finished mask that is never emptied, or that gathers tags while reception is off, shows as extra bits in bytes 4..7 of the next set-device-bits frame. It also shows as active bits vanishing from act_rd_data. Wrong error or status bytes appear in the first frame after the completion. A retained error byte is visible only in a later successful completion, so the tests order failures before successes on purpose.

// File: rtl/ncq_pkg.sv
package ncq_pkg;
   localparam int FRAME_BYTES = 16;
   localparam int FRAME_W     = FRAME_BYTES * 8;
   localparam int RAW_TAG_W   = 5;

   // byte positions inside the register frame
   localparam int B_OPCODE = 2;
   localparam int B_CNT_LO = 3;
   localparam int B_LBA0   = 4;
   localparam int B_LBA1   = 5;
   localparam int B_LBA2   = 6;
   localparam int B_LBA3   = 8;
   localparam int B_LBA4   = 9;
   localparam int B_LBA5   = 10;
   localparam int B_CNT_HI = 11;
   localparam int B_TAG    = 12;
   localparam int TAG_SHIFT = 3;

   localparam logic [7:0] OP_QREAD     = 8'h60;
   localparam logic [7:0] OP_QWRITE    = 8'h61;
   localparam logic [7:0] ERR_ABORT    = 8'h04;
   localparam logic [7:0] ST_READY_ERR = 8'h41;
   localparam logic [7:0] ST_READY_SEEK = 8'h50;
   localparam logic [7:0] SDB_ST_MASK  = 8'h77;

   typedef struct packed {
      logic [7:0]           opcode;
      logic [RAW_TAG_W-1:0] raw_tag;
      logic [47:0]          lba;
      logic [15:0]          cnt;
   } ncq_cmd_t;

   function automatic logic is_queued(input logic [7:0] op);
      return (op == OP_QREAD) || (op == OP_QWRITE);
   endfunction
endpackage

// File: rtl/ncq_frame_decode.sv
module ncq_frame_decode
   import ncq_pkg::*;
(
   input  logic [FRAME_W-1:0] frame,
   output ncq_cmd_t           cmd
);
   logic [7:0] fb [FRAME_BYTES];

   generate
      for (genvar i = 0; i < FRAME_BYTES; i++) begin : g_bytes
         assign fb[i] = frame[8*i +: 8];
      end
   endgenerate

   logic [7:0] tag_byte;
   assign tag_byte = fb[B_TAG] >> TAG_SHIFT;

   assign cmd.opcode  = fb[B_OPCODE];
   assign cmd.raw_tag = tag_byte[RAW_TAG_W-1:0];
   assign cmd.lba     = {fb[B_LBA5], fb[B_LBA4], fb[B_LBA3],
                         fb[B_LBA2], fb[B_LBA1], fb[B_LBA0]};
   assign cmd.cnt     = {fb[B_CNT_HI], fb[B_CNT_LO]};

   logic unused_bytes;
   assign unused_bytes = ^{fb[0], fb[1], fb[7], fb[13], fb[14], fb[15], tag_byte[7:RAW_TAG_W]};
endmodule

// File: rtl/ncq_tag_table.sv
module ncq_tag_table #(
   parameter int NUM_TAGS = 32,
   localparam int TAG_W = $clog2(NUM_TAGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                port_rst,
   input  logic                set_en,
   input  logic [TAG_W-1:0]    set_idx,
   input  logic                clr_en,
   input  logic [TAG_W-1:0]    clr_idx,
   output logic [NUM_TAGS-1:0] used
);
   // set wins over clear: a same-cycle completion is applied first
   generate
      for (genvar t = 0; t < NUM_TAGS; t++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   used[t] <= 1'b0;
            else if (port_rst)                            used[t] <= 1'b0;
            else if (set_en && (set_idx == TAG_W'(t)))    used[t] <= 1'b1;
            else if (clr_en && (clr_idx == TAG_W'(t)))    used[t] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/ncq_cpl_unit.sv
module ncq_cpl_unit
   import ncq_pkg::*;
#(
   parameter int NUM_TAGS = 32,
   localparam int TAG_W = $clog2(NUM_TAGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpl_valid,
   input  logic [TAG_W-1:0]    cpl_tag,
   input  logic                cpl_err,
   input  logic                sdb_enable,
   input  logic                act_set_en,
   input  logic [NUM_TAGS-1:0] act_set_mask,
   input  logic                act_rd,
   output logic [NUM_TAGS-1:0] act_rd_data,
   output logic [NUM_TAGS-1:0] serr,
   output logic                sdb_irq,
   output logic [63:0]         sdb_frame
);
   logic [NUM_TAGS-1:0] sactive_q, finished_q;
   logic [NUM_TAGS-1:0] cpl_bit, fin_base, fin_n, act_base, act_n, serr_n;
   logic [7:0]          err_q, stat_q, err_n, stat_n;
   logic                emit;

   always_comb begin
      cpl_bit  = cpl_valid ? (NUM_TAGS'(1) << cpl_tag) : '0;
      emit     = cpl_valid && sdb_enable;
      fin_base = act_rd ? '0 : finished_q;
      fin_n    = emit ? (fin_base | cpl_bit) : fin_base;
      act_base = act_rd ? (sactive_q & ~finished_q) : sactive_q;
      act_n    = (act_base | (act_set_en ? act_set_mask : '0)) & ~cpl_bit;
      serr_n   = serr | ((cpl_valid && cpl_err) ? cpl_bit : '0);
      err_n    = (cpl_valid && cpl_err) ? ERR_ABORT : err_q;
      stat_n   = cpl_valid ? (cpl_err ? ST_READY_ERR : ST_READY_SEEK) : stat_q;
   end

   assign act_rd_data = sactive_q & ~finished_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sactive_q  <= '0;
         finished_q <= '0;
         serr       <= '0;
         err_q      <= '0;
         stat_q     <= '0;
         sdb_irq    <= 1'b0;
         sdb_frame  <= '0;
      end else begin
         sactive_q  <= act_n;
         finished_q <= fin_n;
         serr       <= serr_n;
         err_q      <= err_n;
         stat_q     <= stat_n;
         sdb_irq    <= emit;
         if (emit)
            sdb_frame <= {32'(fin_n), 8'h00, stat_n & SDB_ST_MASK, 8'h00, err_n};
      end
   end
endmodule

// File: rtl/ncq_tag_tracker.sv
module ncq_tag_tracker
   import ncq_pkg::*;
#(
   parameter int NUM_TAGS = 32,
   localparam int TAG_W = $clog2(NUM_TAGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                port_rst,
   input  logic                iss_valid,
   input  logic [127:0]        iss_frame,
   input  logic                cpl_valid,
   input  logic [TAG_W-1:0]    cpl_tag,
   input  logic                cpl_err,
   input  logic                fis_rx_en,
   input  logic                rx_area_ok,
   input  logic                act_set_en,
   input  logic [NUM_TAGS-1:0] act_set_mask,
   input  logic                act_rd,
   output logic [NUM_TAGS-1:0] act_rd_data,
   output logic                start_valid,
   output logic [TAG_W-1:0]    start_tag,
   output logic [47:0]         start_lba,
   output logic [15:0]         start_cnt,
   output logic                start_is_read,
   output logic [NUM_TAGS-1:0] tags_used,
   output logic [NUM_TAGS-1:0] serr,
   output logic                sdb_irq,
   output logic [63:0]         sdb_frame
);
   if (NUM_TAGS < 2 || NUM_TAGS > 32 || NUM_TAGS != (1 << TAG_W)) begin : g_bad_cfg
      $error("NUM_TAGS must be a power of two from 2 to 32");
   end
   if (FRAME_W != 128) begin : g_bad_frame
      $error("frame width must be 128 bits");
   end

   ncq_cmd_t         cmd;
   logic [TAG_W-1:0] iss_tag;
   logic             tag_in_range, tag_busy, accept;

   ncq_frame_decode u_dec (.frame(iss_frame), .cmd(cmd));

   assign iss_tag = cmd.raw_tag[TAG_W-1:0];

   generate
      if (TAG_W == RAW_TAG_W) begin : g_full_tags
         assign tag_in_range = 1'b1;
      end else begin : g_narrow_tags
         assign tag_in_range = (cmd.raw_tag[RAW_TAG_W-1:TAG_W] == '0);
      end
   endgenerate

   // a completion to the same tag this cycle frees it before the check
   assign tag_busy = tags_used[iss_tag] && !(cpl_valid && (cpl_tag == iss_tag));
   assign accept   = iss_valid && !port_rst && tag_in_range && !tag_busy
                     && is_queued(cmd.opcode);

   ncq_tag_table #(.NUM_TAGS(NUM_TAGS)) u_table (
      .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
      .set_en(accept), .set_idx(iss_tag),
      .clr_en(cpl_valid), .clr_idx(cpl_tag),
      .used(tags_used)
   );

   ncq_cpl_unit #(.NUM_TAGS(NUM_TAGS)) u_cpl (
      .clk(clk), .rst_n(rst_n),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_err(cpl_err),
      .sdb_enable(fis_rx_en && rx_area_ok),
      .act_set_en(act_set_en), .act_set_mask(act_set_mask), .act_rd(act_rd),
      .act_rd_data(act_rd_data), .serr(serr),
      .sdb_irq(sdb_irq), .sdb_frame(sdb_frame)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_valid   <= 1'b0;
         start_tag     <= '0;
         start_lba     <= '0;
         start_cnt     <= '0;
         start_is_read <= 1'b0;
      end else begin
         start_valid <= accept;
         if (accept) begin
            start_tag     <= iss_tag;
            start_lba     <= cmd.lba;
            start_cnt     <= cmd.cnt;
            start_is_read <= (cmd.opcode == OP_QREAD);
         end
      end
   end
endmodule

// File: rtl/ncq_tag_tracker_chk.sv
module ncq_tag_tracker_chk #(
   parameter int NUM_TAGS = 32,
   localparam int TAG_W = $clog2(NUM_TAGS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                port_rst,
   input logic                iss_valid,
   input logic [4:0]          chk_raw_tag,
   input logic                cpl_valid,
   input logic [TAG_W-1:0]    cpl_tag,
   input logic                cpl_err,
   input logic                fis_rx_en,
   input logic                rx_area_ok,
   input logic                start_valid,
   input logic [TAG_W-1:0]    start_tag,
   input logic [NUM_TAGS-1:0] tags_used,
   input logic [NUM_TAGS-1:0] serr,
   input logic                sdb_irq
);
   logic [TAG_W-1:0] fr_tag;
   assign fr_tag = chk_raw_tag[TAG_W-1:0];

   assert_start_marks_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_valid |-> tags_used[start_tag]);

   assert_dup_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !port_rst && tags_used[fr_tag] && !(cpl_valid && cpl_tag == fr_tag))
      |=> !start_valid);

   assert_cpl_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !(iss_valid && fr_tag == cpl_tag)) |=> !tags_used[$past(cpl_tag)]);

   assert_err_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && cpl_err) |=> serr[$past(cpl_tag)]);

   assert_no_sdb_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(fis_rx_en && rx_area_ok) |=> !sdb_irq);

   assert_port_rst_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst |=> (tags_used == '0));
endmodule

bind ncq_tag_tracker ncq_tag_tracker_chk #(.NUM_TAGS(NUM_TAGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .iss_valid(iss_valid),
   .chk_raw_tag(iss_frame[103:99]), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
   .cpl_err(cpl_err), .fis_rx_en(fis_rx_en), .rx_area_ok(rx_area_ok),
   .start_valid(start_valid), .start_tag(start_tag), .tags_used(tags_used),
   .serr(serr), .sdb_irq(sdb_irq)
);

// File: tb/sim_ncq_tag_tracker.sv
module sim_ncq_tag_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 32;

   logic clk = 1'b0, rst_n = 1'b0, port_rst = 1'b0, iss_valid = 1'b0;
   logic [127:0] iss_frame = '0;
   logic cpl_valid = 1'b0, cpl_err = 1'b0, fis_rx_en = 1'b1, rx_area_ok = 1'b1;
   logic [4:0] cpl_tag = '0;
   logic act_set_en = 1'b0, act_rd = 1'b0;
   logic [NT-1:0] act_set_mask = '0;
   logic [NT-1:0] act_rd_data, tags_used, serr;
   logic start_valid, start_is_read, sdb_irq;
   logic [4:0] start_tag;
   logic [47:0] start_lba;
   logic [15:0] start_cnt;
   logic [63:0] sdb_frame;

   int checks = 0, errors = 0;
   logic [NT-1:0] act_m = '0, fin_m = '0;
   logic [7:0] err_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ncq_tag_tracker #(.NUM_TAGS(NT)) u0 (.*);

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [127:0] mk(logic [7:0] op, int tg, logic [47:0] lba, logic [15:0] cnt);
      logic [127:0] f = '0;
      f[7:0] = 8'h27; f[23:16] = op; f[31:24] = cnt[7:0];
      f[39:32] = lba[7:0]; f[47:40] = lba[15:8]; f[55:48] = lba[23:16];
      f[71:64] = lba[31:24]; f[79:72] = lba[39:32]; f[87:80] = lba[47:40];
      f[95:88] = cnt[15:8]; f[103:96] = 8'(tg << 3);
      return f;
   endfunction

   task automatic issue(logic [7:0] op, int tg, logic [47:0] lba, logic [15:0] cnt);
      @(negedge clk); iss_valid = 1'b1; iss_frame = mk(op, tg, lba, cnt);
      @(negedge clk); iss_valid = 1'b0;
   endtask

   task automatic complete(int tg, logic e);
      @(negedge clk); cpl_valid = 1'b1; cpl_tag = 5'(tg); cpl_err = e;
      @(negedge clk); cpl_valid = 1'b0; cpl_err = 1'b0;
      act_m &= ~(NT'(1) << tg);
      if (fis_rx_en && rx_area_ok) fin_m |= NT'(1) << tg;
      if (e) err_m = 8'h04;
   endtask

   task automatic set_act(logic [NT-1:0] m);
      @(negedge clk); act_set_en = 1'b1; act_set_mask = m;
      @(negedge clk); act_set_en = 1'b0;
      act_m |= m;
   endtask

   task automatic t_reset;
      chk("R1", "tags_used", 64'(tags_used), 0);
      chk("R1", "act_rd_data", 64'(act_rd_data), 0);
      chk("R1", "serr", 64'(serr), 0);
      chk("R1", "start_valid", 64'(start_valid), 0);
      chk("R1", "sdb_irq", 64'(sdb_irq), 0);
   endtask

   task automatic t_issue_fields;
      issue(8'h60, 5, 48'h0A0B0C0D0E0F, 16'h0123);
      chk("R3", "start_valid", 64'(start_valid), 1);
      chk("R2", "start_tag", 64'(start_tag), 5);
      chk("R2", "start_lba", 64'(start_lba), 64'h0A0B0C0D0E0F);
      chk("R2", "start_cnt", 64'(start_cnt), 16'h0123);
      chk("R2", "is_read", 64'(start_is_read), 1);
      chk("R3", "tags_used", 64'(tags_used), 64'h20);
      @(negedge clk);
      chk("R3", "pulse one cycle", 64'(start_valid), 0);
      issue(8'h61, 31, 48'hFEDCBA987654, 16'hA55A);
      chk("R2", "write tag", 64'(start_tag), 31);
      chk("R2", "write lba", 64'(start_lba), 64'hFEDCBA987654);
      chk("R2", "write is_read", 64'(start_is_read), 0);
   endtask

   task automatic t_duplicate;
      issue(8'h61, 5, 48'h1, 16'h1);
      chk("R4", "dup start_valid", 64'(start_valid), 0);
      chk("R4", "dup tags_used", 64'(tags_used), 64'h80000020);
   endtask

   task automatic t_other_opcode;
      issue(8'hC8, 9, 48'h2, 16'h2);
      chk("R5", "other start_valid", 64'(start_valid), 0);
      chk("R5", "other tags_used", 64'(tags_used), 64'h80000020);
   endtask

   task automatic t_complete;
      set_act(32'h80000020);
      chk("R14", "act set", 64'(act_rd_data), 64'(act_m));
      complete(31, 1'b1);
      chk("R9", "sdb_irq err", 64'(sdb_irq), 1);
      chk("R7", "err byte0", 64'(sdb_frame[7:0]), 8'h04);
      chk("R7", "err status", 64'(sdb_frame[23:16]), 8'h41);
      chk("R7", "serr", 64'(serr), 64'h80000000);
      chk("R9", "finished", 64'(sdb_frame[63:32]), 64'(fin_m));
      chk("R6", "tags_used", 64'(tags_used), 64'h20);
      chk("R6", "active", 64'(act_rd_data), 64'(act_m & ~fin_m));
      complete(5, 1'b0);
      chk("R8", "ok status", 64'(sdb_frame[23:16]), 8'h50);
      chk("R8", "err byte kept", 64'(sdb_frame[7:0]), 64'(err_m));
      chk("R9", "frame bytes 1,3", 64'({sdb_frame[31:24], sdb_frame[15:8]}), 0);
      chk("R9", "finished accum", 64'(sdb_frame[63:32]), 64'h80000020);
      chk("R6", "tags_used free", 64'(tags_used), 0);
   endtask

   task automatic t_gated;
      fis_rx_en = 1'b0;
      issue(8'h60, 7, 48'h7, 16'h7);
      complete(7, 1'b0);
      chk("R10", "no sdb rx off", 64'(sdb_irq), 0);
      fis_rx_en = 1'b1; rx_area_ok = 1'b0;
      issue(8'h60, 6, 48'h6, 16'h6);
      complete(6, 1'b0);
      chk("R10", "no sdb area bad", 64'(sdb_irq), 0);
      rx_area_ok = 1'b1;
      issue(8'h60, 8, 48'h8, 16'h8);
      complete(8, 1'b0);
      chk("R10", "finished excludes gated", 64'(sdb_frame[63:32]), 64'(fin_m));
   endtask

   task automatic t_read;
      logic [NT-1:0] exp_rd;
      set_act(32'h000001FF);
      exp_rd = act_m & ~fin_m;
      @(negedge clk); act_rd = 1'b1;
      #1 chk("R11", "read value", 64'(act_rd_data), 64'(exp_rd));
      @(negedge clk); act_rd = 1'b0;
      act_m = exp_rd; fin_m = '0;
      chk("R11", "after read", 64'(act_rd_data), 64'(act_m));
      issue(8'h61, 1, 48'h1, 16'h1);
      complete(1, 1'b0);
      chk("R11", "finished emptied", 64'(sdb_frame[63:32]), 64'h2);
   endtask

   task automatic t_port_reset;
      issue(8'h60, 10, 48'hA, 16'hA);
      issue(8'h60, 11, 48'hB, 16'hB);
      chk("R12", "before reset", 64'(tags_used), 64'h00000C00);
      @(negedge clk); port_rst = 1'b1;
      @(negedge clk); port_rst = 1'b0;
      chk("R12", "after reset", 64'(tags_used), 0);
      issue(8'h60, 10, 48'hA, 16'hA);
      chk("R12", "reissue accepted", 64'(start_valid), 1);
      complete(10, 1'b0);
   endtask

   task automatic t_same_cycle;
      issue(8'h60, 12, 48'h12, 16'h12);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_tag = 5'd12;
      iss_valid = 1'b1; iss_frame = mk(8'h61, 12, 48'h3456, 16'h9);
      @(negedge clk);
      cpl_valid = 1'b0; iss_valid = 1'b0;
      chk("R13", "start_valid", 64'(start_valid), 1);
      chk("R13", "start_lba", 64'(start_lba), 64'h3456);
      chk("R13", "tags_used", 64'(tags_used), 64'h1000);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_issue_fields();
      t_duplicate();
      t_other_opcode();
      t_complete();
      t_gated();
      t_read();
      t_port_reset();
      t_same_cycle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule